// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two single-precision binary floating-point numbers (1 sign bit, 8-bit biased exponent with bias 127, 23-bit fraction) and returns a single-precision result rounded to nearest, ties to even. It covers the whole datapath. The operands are ordered by magnitude. The smaller one is shifted right to the larger exponent while guard, round and sticky bits are kept. The significands are then added or subtracted, the sum is normalized and rounded, and it is normalized a second time when rounding carries out of the significand.

Special encodings are handled before the arithmetic result is used: signed zeros, denormals, infinities and NaNs. Two flags report a result that left the normal range, one for overflow and one for a denormal (tiny) result. Operands are sampled together with a valid strobe. Result and flags appear one clock later with a matching valid and hold their value while no new operation arrives.

Top module: `fp_addsub`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock. `result`, `overflow` and `underflow` are loaded only on a cycle with `in_valid` high and hold otherwise. Reset drives all outputs to 0.
- R2: For finite normal operands, `result` is the exact sum rounded to the nearest representable value, with ties going to an even fraction (fraction bit 0 clear).
- R3: With `op_sub` high, the block returns op_a + (−op_b), meaning operand B's sign bit (bit 31) is inverted before the add.
- R4: Bits shifted below the round position during alignment are kept as sticky. 0x3F800000 + 0x33800000 gives 0x3F800000 (tie, even kept). 0x3F800000 + 0x33800001 gives 0x3F800001. 0x3F800001 + 0x33800000 gives 0x3F800002.
- R5: When rounding carries out of the significand, the exponent is incremented and the fraction cleared: 0x3FFFFFFF + 0x33800000 gives 0x40000000.
- R6: An exact zero sum is +0 (0x00000000), except when both addends are −0, which gives −0 (0x80000000).
- R7: Any operand with exponent field 255 and a nonzero fraction produces the quiet NaN 0x7FC00000.
- R8: Exponent field 255 with a zero fraction is an infinity. Infinity plus a finite value returns that infinity. Infinities of opposite effective sign produce 0x7FC00000. Infinities of the same sign return that infinity. Flags stay clear in all these cases.
- R9: Exponent field 0 with a nonzero fraction is a denormal: it has no hidden 1 and an exponent of −126. A denormal sum that reaches 2^−126 becomes normal (0x007FFFFF + 0x00000001 = 0x00800000).
- R10: A finite sum whose rounded magnitude reaches 2^128 returns an infinity with the sign of the larger-magnitude operand and sets `overflow`. This includes overflow caused only by rounding (0x7F7FFFFF + 0x73000000 = 0x7F800000).
- R11: `underflow` is set exactly when the returned result is a nonzero denormal (exponent field 0, fraction nonzero). `overflow` and `underflow` are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1 selects op_a − op_b, 0 selects op_a + op_b |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 32 | Rounded sum or difference |
| overflow | output | 1 | Finite operands produced an infinity |
| underflow | output | 1 | Result is a nonzero denormal |

## Verification
Because the block has a single register stage, any wrong alignment shift, sticky collection, normalization count or rounding decision appears in `result` on the cycle right after the operation is presented. The first sign is usually a one-ulp error or an exponent off by one. Loss of sticky shows only on ties, and a missing renormalization shows only on all-ones fractions, so directed vectors target those exact bit patterns. Random normal sums with exponent gaps of up to 20 are compared against an exact real-valued reference, and an exhaustive-style sweep of denormal pairs checks the boundary into the normal range, where an error also shows up as a wrong `underflow`.

// File: rtl/fp_addsub.sv
module fp_addsub #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [EW+FW:0] op_a,
  input  logic [EW+FW:0] op_b,
  input  logic          op_sub,
  output logic          out_valid,
  output logic [EW+FW:0] result,
  output logic          overflow,
  output logic          underflow
);
  localparam int W  = EW + FW + 1;
  localparam int MW = FW + 1;
  localparam int GW = MW + 3;
  localparam int XW = 2 * MW + 3;
  localparam logic [EW-1:0] EMAX = '1;
  localparam logic [EW-1:0] SH_CAP = EW'(MW + 2);
  localparam logic [W-1:0] QNAN = {1'b0, EMAX, 1'b1, {(FW-1){1'b0}}};

  logic          sa, sb;
  logic [EW-1:0] xa, xb;
  logic [FW-1:0] fa, fb;
  logic          a_nan, b_nan, a_inf, b_inf;

  assign sa = op_a[W-1];
  assign sb = op_b[W-1] ^ op_sub;
  assign xa = op_a[W-2:FW];
  assign xb = op_b[W-2:FW];
  assign fa = op_a[FW-1:0];
  assign fb = op_b[FW-1:0];
  assign a_nan = (xa == EMAX) && (fa != '0);
  assign b_nan = (xb == EMAX) && (fb != '0);
  assign a_inf = (xa == EMAX) && (fa == '0);
  assign b_inf = (xb == EMAX) && (fb == '0);

  logic          a_big, big_s;
  logic [EW-1:0] big_x, sml_x, big_e, sml_e, diff, shamt;
  logic [FW-1:0] big_f, sml_f;
  logic [MW-1:0] big_m, sml_m;
  logic [XW-1:0] wide;
  logic [GW-1:0] al_b, al_s;
  logic [GW:0]   sum;

  assign a_big = op_a[W-2:0] >= op_b[W-2:0];
  assign big_s = a_big ? sa : sb;
  assign big_x = a_big ? xa : xb;
  assign sml_x = a_big ? xb : xa;
  assign big_f = a_big ? fa : fb;
  assign sml_f = a_big ? fb : fa;
  assign big_e = (big_x == '0) ? EW'(1) : big_x;
  assign sml_e = (sml_x == '0) ? EW'(1) : sml_x;
  assign big_m = {big_x != '0, big_f};
  assign sml_m = {sml_x != '0, sml_f};
  assign diff  = big_e - sml_e;
  assign shamt = (diff > SH_CAP) ? SH_CAP : diff;
  assign wide  = {sml_m, {(MW+3){1'b0}}} >> shamt;
  assign al_b  = {big_m, 3'b000};
  assign al_s  = {wide[XW-1:MW+1], |wide[MW:0]};
  assign sum   = (sa ^ sb) ? ({1'b0, al_b} - {1'b0, al_s})
                           : ({1'b0, al_b} + {1'b0, al_s});

  logic [EW:0]   e0, en, e2;
  logic [GW-1:0] nrm;
  int            lz, lim, sh;

  assign e0 = {1'b0, big_e};

  always_comb begin
    lz = GW;
    for (int i = 0; i < GW; i++)
      if (sum[i]) lz = GW - 1 - i;
    lim = int'(e0) - 1;
    sh  = (lz < lim) ? lz : lim;
    if (sum[GW]) begin
      nrm = {sum[GW:2], sum[1] | sum[0]};
      en  = e0 + 1'b1;
    end else begin
      nrm = sum[GW-1:0] << sh;
      en  = e0 - (EW+1)'(sh);
    end
  end

  logic          up, hid, ovf;
  logic [MW:0]   rnd;
  logic [FW-1:0] frc;
  logic [EW-1:0] fin_x;

  assign up    = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
  assign rnd   = {1'b0, nrm[GW-1:3]} + {{MW{1'b0}}, up};
  assign e2    = rnd[MW] ? en + 1'b1 : en;
  assign hid   = rnd[MW] | rnd[FW];
  assign frc   = rnd[MW] ? '0 : rnd[FW-1:0];
  assign ovf   = hid && (e2 >= {1'b0, EMAX});
  assign fin_x = hid ? e2[EW-1:0] : '0;

  logic [W-1:0] nxt_res;
  logic         nxt_ovf, nxt_unf;

  always_comb begin
    nxt_ovf = 1'b0;
    nxt_unf = 1'b0;
    if (a_nan || b_nan || (a_inf && b_inf && (sa != sb)))
      nxt_res = QNAN;
    else if (a_inf)
      nxt_res = {sa, EMAX, {FW{1'b0}}};
    else if (b_inf)
      nxt_res = {sb, EMAX, {FW{1'b0}}};
    else if (sum == '0)
      nxt_res = {sa & sb, {(W-1){1'b0}}};
    else if (ovf) begin
      nxt_res = {big_s, EMAX, {FW{1'b0}}};
      nxt_ovf = 1'b1;
    end else begin
      nxt_res = {big_s, fin_x, frc};
      nxt_unf = !hid && (frc != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        overflow  <= nxt_ovf;
        underflow <= nxt_unf;
      end
    end
  end
endmodule

// File: rtl/fp_addsub_chk.sv
module fp_addsub_chk #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [EW+FW:0] op_a,
  input logic [EW+FW:0] op_b,
  input logic          op_sub,
  input logic          out_valid,
  input logic [EW+FW:0] result,
  input logic          overflow,
  input logic          underflow
);
  localparam int W = EW + FW + 1;
  localparam logic [EW-1:0] EMAX = '1;
  localparam logic [W-1:0] QNAN = {1'b0, EMAX, 1'b1, {(FW-1){1'b0}}};

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(overflow) && $stable(underflow)));

  assert_cancel_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_a[W-2:0] == op_b[W-2:0] && op_a[W-2:FW] != EMAX &&
     op_a[W-1] != (op_b[W-1] ^ op_sub)) |=> result == '0);

  assert_nan_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_a[W-2:FW] == EMAX && op_a[FW-1:0] != '0) |=> result == QNAN);

  assert_inf_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_a[W-2:0] == {EMAX, {FW{1'b0}}} && op_b[W-2:FW] != EMAX)
    |=> (result[W-1] == $past(op_a[W-1]) && result[W-2:0] == {EMAX, {FW{1'b0}}}
         && !overflow && !underflow));

  assert_ovf_inf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> result[W-2:0] == {EMAX, {FW{1'b0}}});

  assert_unf_denorm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (result[W-2:FW] == '0 && result[FW-1:0] != '0 && !overflow));
endmodule

bind fp_addsub fp_addsub_chk #(.EW(EW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .op_sub(op_sub), .out_valid(out_valid), .result(result),
  .overflow(overflow), .underflow(underflow)
);

// File: tb/fp_addsub_tb.sv
`timescale 1ns/1ps
module fp_addsub_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        op_sub = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        overflow, underflow;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  fp_addsub u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_sub(op_sub), .out_valid(out_valid), .result(result),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic s,
                     input logic [31:0] exp, input logic eo, input logic eu,
                     input string tag);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(result, exp, tag);
    chk({30'd0, overflow, underflow}, {30'd0, eo, eu}, {tag, " flags"});
    chk({31'd0, out_valid}, 32'd1, {tag, " valid"});
  endtask

  function automatic real f2r(input logic [31:0] x);
    real m;
    int  e;
    m = 1.0 + real'(x[22:0]) / 8388608.0;
    e = int'(x[30:23]) - 127;
    while (e > 0) begin m = m * 2.0; e--; end
    while (e < 0) begin m = m / 2.0; e++; end
    return x[31] ? -m : m;
  endfunction

  function automatic logic [31:0] r2f(input real r);
    logic  s;
    int    e;
    real   m, fl, fr;
    longint li;
    if (r == 0.0) return 32'h0;
    s = r < 0.0;
    m = s ? -r : r;
    e = 0;
    while (m >= 2.0) begin m = m / 2.0; e++; end
    while (m < 1.0) begin m = m * 2.0; e--; end
    m  = m * 8388608.0;
    fl = $floor(m);
    fr = m - fl;
    li = longint'(fl);
    if (fr > 0.5 || (fr == 0.5 && li[0])) li++;
    if (li == 64'd16777216) begin li = 64'd8388608; e++; end
    return {s, 8'(e + 127), li[22:0]};
  endfunction

  initial begin
    #(8ns * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(result, 32'h0, "R1 reset result");
    chk({31'd0, out_valid}, 32'd0, "R1 reset valid");
    rst_n = 1'b1;
    @(negedge clk);

    run(32'h3F800000, 32'h40000000, 0, 32'h40400000, 0, 0, "R2 1+2");
    run(32'h3FC00000, 32'h3FC00000, 0, 32'h40400000, 0, 0, "R2 1.5+1.5");
    run(32'h40400000, 32'h3F800000, 1, 32'h40000000, 0, 0, "R3 3-1");
    run(32'h3F800000, 32'h40400000, 1, 32'hC0000000, 0, 0, "R3 1-3");
    run(32'h3F800000, 32'hBF800000, 1, 32'h40000000, 0, 0, "R3 1-(-1)");
    run(32'h3F800000, 32'h33800000, 0, 32'h3F800000, 0, 0, "R4 tie even");
    run(32'h3F800000, 32'h33800001, 0, 32'h3F800001, 0, 0, "R4 sticky");
    run(32'h3F800001, 32'h33800000, 0, 32'h3F800002, 0, 0, "R4 tie odd");
    run(32'h3F800000, 32'h00000001, 0, 32'h3F800000, 0, 0, "R4 far shift");
    run(32'h3FFFFFFF, 32'h33800000, 0, 32'h40000000, 0, 0, "R5 renorm");
    run(32'h3F800000, 32'h3F800000, 1, 32'h00000000, 0, 0, "R6 x-x");
    run(32'h80000000, 32'h80000000, 0, 32'h80000000, 0, 0, "R6 -0+-0");
    run(32'h00000000, 32'h80000000, 0, 32'h00000000, 0, 0, "R6 +0+-0");
    run(32'hC1200000, 32'h41200000, 0, 32'h00000000, 0, 0, "R6 -10+10");
    run(32'h7FC12345, 32'h3F800000, 0, 32'h7FC00000, 0, 0, "R7 nan a");
    run(32'h3F800000, 32'hFF800001, 1, 32'h7FC00000, 0, 0, "R7 nan b");
    run(32'h7F800000, 32'h7F800000, 1, 32'h7FC00000, 0, 0, "R8 inf-inf");
    run(32'h7F800000, 32'hFF800000, 0, 32'h7FC00000, 0, 0, "R8 inf+-inf");
    run(32'hFF800000, 32'hFF800000, 0, 32'hFF800000, 0, 0, "R8 -inf+-inf");
    run(32'h3F800000, 32'h7F800000, 1, 32'hFF800000, 0, 0, "R8 1-inf");
    run(32'h7F800000, 32'h7F7FFFFF, 0, 32'h7F800000, 0, 0, "R8 inf+max");
    run(32'h007FFFFF, 32'h00000001, 0, 32'h00800000, 0, 0, "R9 to normal");
    run(32'h00800000, 32'h00000001, 1, 32'h007FFFFF, 0, 1, "R9 to denorm");
    run(32'h00800000, 32'h00400000, 0, 32'h00C00000, 0, 0, "R9 mixed");
    run(32'h7F7FFFFF, 32'h7F7FFFFF, 0, 32'h7F800000, 1, 0, "R10 ovf");
    run(32'h7F7FFFFF, 32'h73000000, 0, 32'h7F800000, 1, 0, "R10 round ovf");
    run(32'hFF7FFFFF, 32'h7F7FFFFF, 1, 32'hFF800000, 1, 0, "R10 neg ovf");
    run(32'h7F7FFFFF, 32'h72FFFFFF, 0, 32'h7F7FFFFF, 0, 0, "R10 no ovf");
    run(32'h00000003, 32'h00000001, 1, 32'h00000002, 0, 1, "R11 denorm diff");

    @(negedge clk);
    op_a = 32'h40000000; op_b = 32'h40000000; op_sub = 1'b0;
    @(negedge clk);
    chk(result, 32'h00000002, "R1 idle hold result");
    chk({31'd0, out_valid}, 32'd0, "R1 idle valid low");

    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [31:0] a, b, e;
        a = i * 32'h7FFFF + i;
        b = j * 32'h7FFFF + 3 * j;
        e = a + b;
        run(a, b, 0, e, 0, (e[30:23] == 0 && e != 0), "R9 denorm sweep add");
        if (a >= b) e = a - b; else e = {1'b1, 31'(b - a)};
        run(a, b, 1, e, 0, (e[30:0] != 0), "R11 denorm sweep sub");
      end
    end

    for (int k = 0; k < 2000; k++) begin
      logic [31:0] a, b, e;
      logic        s;
      int          xa, d;
      real         r;
      xa = 60 + int'($urandom % 130);
      d  = int'($urandom % 21);
      a  = {$urandom % 2 == 1, 8'(xa), 23'($urandom)};
      b  = {$urandom % 2 == 1, 8'(xa - d), 23'($urandom)};
      s  = ($urandom % 2) == 1;
      if (k % 2 == 1) begin e = a; a = b; b = e; end
      r = s ? f2r(a) - f2r(b) : f2r(a) + f2r(b);
      e = r2f(r);
      run(a, b, s, e, 0, 0, s ? "R3 random sub" : "R2 random add");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule